// File: doc/BRIEF.md
# Paired-Word Cipher Key Table

This block holds a table of cipher key entries. A host reaches it through a plain 32-bit register interface, but each storage location behind it is 64 bits wide. Every entry spans eight 32-bit register slots, and these are grouped into four even/odd pairs. Each pair sits in one 64-bit storage word. A write to an even slot is only staged. The write to the matching odd slot then commits both halves in the same cycle, so a lookup never sees a half-updated pair.

A second read port hands a whole entry (all eight slots) to a lookup engine one cycle after it presents an index. One power-management flag per entry belongs to the MAC side. The MAC sets it through its own port, and host writes to the type word never alter it. The type word also carries the cipher code. From that code the table rejects a TKIP entry whose companion slot (index + MIC_GAP) would fall outside the table, and it narrows how much of the fifth key word is shown.

Top module: `keytab_pairfile`

## Requirements
- R1: The register address is entry index times 8 plus slot. Slots 0 to 4 are key words 0 to 4, slot 5 is the type word, and slots 6 and 7 are address words 0 and 1. rd_data shows the addressed register one clock after rd_addr is presented. Writing one entry's slots leaves every other entry unchanged.
- R2: A write to an even slot changes no readable state. The next write to the odd slot of the same entry and pair makes both halves readable together.
- R3: If two even writes reach the same pair before its odd write, the later even value is committed. An odd write with no matching staged even write commits only the odd half, and the stored even half keeps its previous value.
- R4: Slots 1, 3 and 7 keep only their low 16 bits. Their bits 31:16 read as zero.
- R5: When the stored cipher code is 1 (40-bit) or 2 (104-bit), slot 4 reads back only its low 8 bits, with the upper 24 bits as zero. For every other code, all 32 bits of slot 4 read back.
- R6: Type word layout: bits 2:0 hold the cipher code (0 clear, 1 40-bit, 2 104-bit, 3 128-bit, 4 TKIP, 5 AES, 6 CCM), bit 3 the power-management flag, bits 7:4 the power-save class field, and bit 8 the ack-direction bit. Bits 31:9 read as zero.
- R7: The power-management flag of an entry changes only through pm_set_en/pm_idx/pm_val. A host write to slot 5 leaves it unchanged, whatever value bit 3 carries.
- R8: An odd write to slot 5 with cipher code 4 at an entry N where N + MIC_GAP >= ENTRIES (entries 64 to 127 by default) commits neither half and discards the staged half.
- R9: A write to an entry index >= ENTRIES is ignored. Reading or looking up such an index returns zero.
- R10: After reset, every register of every entry reads zero: cipher clear, flag cleared, and address word 1 bit 15 (the valid bit) low.
- R11: Presenting lk_idx yields, one clock later, all eight slots on lk_entry, with slot s at bits 32s+31:32s and the same views as host reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | ADDR_W | Host write address {entry, slot} |
| wr_data | input | 32 | Host write data |
| rd_addr | input | ADDR_W | Host read address {entry, slot} |
| rd_data | output | 32 | Host read data, one cycle after rd_addr |
| lk_idx | input | IDX_W | Lookup entry index |
| lk_entry | output | 256 | Whole entry, one cycle after lk_idx |
| pm_set_en | input | 1 | MAC-side power-management update strobe |
| pm_idx | input | IDX_W | Entry whose flag is updated |
| pm_val | input | 1 | New power-management flag value |

## Verification
The bench targets pair atomicity. A design that committed the even half right away would show key word 0 before key word 1 has been written, and a design that always wrote both halves would zero a stored even half on an odd-only write. It places TKIP type writes on both sides of the companion-range boundary (entries 63 and 64) and at out-of-range indices that alias onto real entries, which exposes any check that only looks at the truncated index. Type writes with bit 3 set and cleared, mixed with MAC-side flag updates, show whether host traffic leaks into the power-management flag. Random writes with shifting cipher codes show whether the narrowed view of key word 4 follows the stored code.

// File: rtl/kt_pkg.sv
package kt_pkg;
  localparam int SLOTS  = 8;
  localparam int WORD_W = 32;
  localparam int PM_BIT = 3;
  localparam logic [WORD_W-1:0] TYPE_KEEP = 32'h0000_01F7;

  typedef enum logic [2:0] {
    CIPH_NONE   = 3'd0,
    CIPH_WEP40  = 3'd1,
    CIPH_WEP104 = 3'd2,
    CIPH_WEP128 = 3'd3,
    CIPH_TKIP   = 3'd4,
    CIPH_AES    = 3'd5,
    CIPH_CCM    = 3'd6
  } cipher_e;

  // Significant-bit shaping applied to an odd half before it is stored.
  function automatic logic [WORD_W-1:0] odd_fix(input logic [2:0] slot,
                                                input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    case (slot)
      3'd1, 3'd3, 3'd7: r = {16'h0000, d[15:0]};
      3'd5:             r = d & TYPE_KEEP;
      default:          r = d;
    endcase
    return r;
  endfunction

  // View of a stored word as seen by host reads and lookups.
  function automatic logic [WORD_W-1:0] host_view(input logic [2:0] slot,
                                                  input logic [WORD_W-1:0] w,
                                                  input logic [2:0] ciph,
                                                  input logic pm);
    logic [WORD_W-1:0] r;
    r = w;
    if (slot == 3'd4 && (ciph == CIPH_WEP40 || ciph == CIPH_WEP104))
      r = {24'h0, w[7:0]};
    if (slot == 3'd5)
      r[PM_BIT] = pm;
    return r;
  endfunction
endpackage

// File: rtl/kt_bank.sv
module kt_bank #(
  parameter int DEPTH = 128,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [31:0]   wd,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [31:0]   da,
  output logic [31:0]   db
);
  logic [31:0]      mem [DEPTH];
  logic [DEPTH-1:0] written;
  logic [31:0]      qa, qb;
  logic             va, vb;

  // Plain array, no reset: RAM-inferable write plus two registered reads.
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    qa <= mem[ra];
    qb <= mem[rb];
  end

  // Per-location written flag stands in for clearing the array at reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
      va      <= 1'b0;
      vb      <= 1'b0;
    end else begin
      if (we) written[wa] <= 1'b1;
      va <= written[ra];
      vb <= written[rb];
    end
  end

  assign da = va ? qa : '0;
  assign db = vb ? qb : '0;

  assert_unwritten_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !written[ra] |=> (da == 32'h0));
endmodule

// File: rtl/kt_stage.sv
module kt_stage import kt_pkg::*; #(
  parameter int ENTRIES = 128,
  parameter int MIC_GAP = 64,
  parameter int E_W     = 7,
  parameter int IDX_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W+2:0] wr_addr,
  input  logic [31:0]      wr_data,
  output logic             we_lo,
  output logic             we_hi,
  output logic [E_W-1:0]   w_entry,
  output logic [1:0]       w_pair,
  output logic [31:0]      w_lo,
  output logic [31:0]      w_hi
);
  logic [IDX_W-1:0] idx;
  logic [2:0]       slot;
  logic             in_rng, tkip_bad, odd_go, pair_hit;
  logic             stg_vld;
  logic [IDX_W-1:0] stg_idx;
  logic [1:0]       stg_pair;
  logic [31:0]      stg_data;

  assign idx      = wr_addr[IDX_W+2:3];
  assign slot     = wr_addr[2:0];
  assign in_rng   = (32'(idx) < 32'(ENTRIES));
  assign tkip_bad = (slot == 3'd5) && (wr_data[2:0] == CIPH_TKIP) &&
                    ((32'(idx) + 32'(MIC_GAP)) >= 32'(ENTRIES));
  assign odd_go   = wr_en && in_rng && slot[0] && !tkip_bad;
  assign pair_hit = stg_vld && (stg_idx == idx) && (stg_pair == slot[2:1]);

  assign we_hi   = odd_go;
  assign we_lo   = odd_go && pair_hit;
  assign w_entry = idx[E_W-1:0];
  assign w_pair  = slot[2:1];
  assign w_lo    = stg_data;
  assign w_hi    = odd_fix(slot, wr_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_vld  <= 1'b0;
      stg_idx  <= '0;
      stg_pair <= '0;
      stg_data <= '0;
    end else if (wr_en && in_rng) begin
      if (!slot[0]) begin
        stg_vld  <= 1'b1;
        stg_idx  <= idx;
        stg_pair <= slot[2:1];
        stg_data <= wr_data;
      end else begin
        stg_vld  <= 1'b0;
      end
    end
  end

  assert_even_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr[0]) |-> (!we_lo && !we_hi));

  assert_tkip_reject_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[2:0] == 3'd5 && wr_data[2:0] == 3'd4 &&
     (32'(wr_addr[IDX_W+2:3]) + 32'(MIC_GAP) >= 32'(ENTRIES))) |-> (!we_lo && !we_hi));
endmodule

// File: rtl/kt_pmbits.sv
module kt_pmbits #(
  parameter int ENTRIES = 128,
  parameter int E_W     = 7,
  parameter int IDX_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             set_val,
  input  logic [E_W-1:0]   ra,
  input  logic [E_W-1:0]   rb,
  output logic             qa,
  output logic             qb
);
  logic [ENTRIES-1:0] pm;

  always_ff @(posedge clk) begin
    if (rst) begin
      pm <= '0;
      qa <= 1'b0;
      qb <= 1'b0;
    end else begin
      if (set_en && (32'(set_idx) < 32'(ENTRIES))) pm[set_idx[E_W-1:0]] <= set_val;
      qa <= pm[ra];
      qb <= pm[rb];
    end
  end

  assert_pm_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !set_en |=> $stable(pm));
endmodule

// File: rtl/keytab_pairfile.sv
module keytab_pairfile import kt_pkg::*; #(
  parameter int ENTRIES = 128,
  parameter int MIC_GAP = 64,
  localparam int E_W    = $clog2(ENTRIES),
  localparam int IDX_W  = E_W + 1,
  localparam int ADDR_W = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [255:0]      lk_entry,
  input  logic              pm_set_en,
  input  logic [IDX_W-1:0]  pm_idx,
  input  logic              pm_val
);
  logic             we_lo, we_hi;
  logic [E_W-1:0]   w_entry;
  logic [1:0]       w_pair;
  logic [31:0]      w_lo, w_hi;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_in, lk_in, rd_in_q, lk_in_q, pm_a, pm_b;
  logic [2:0]       rd_slot_q;
  logic [SLOTS-1:0][31:0] ha, lb;

  assign rd_idx = rd_addr[ADDR_W-1:3];
  assign rd_in  = (32'(rd_idx) < 32'(ENTRIES));
  assign lk_in  = (32'(lk_idx) < 32'(ENTRIES));

  kt_stage #(.ENTRIES(ENTRIES), .MIC_GAP(MIC_GAP), .E_W(E_W), .IDX_W(IDX_W)) u_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .we_lo(we_lo), .we_hi(we_hi), .w_entry(w_entry), .w_pair(w_pair),
    .w_lo(w_lo), .w_hi(w_hi));

  for (genvar s = 0; s < SLOTS; s++) begin : g_bank
    logic        we_s;
    logic [31:0] wd_s;
    if (s % 2 == 0) begin : g_even
      assign we_s = we_lo && (w_pair == 2'(s / 2));
      assign wd_s = w_lo;
    end else begin : g_odd
      assign we_s = we_hi && (w_pair == 2'(s / 2));
      assign wd_s = w_hi;
    end
    kt_bank #(.DEPTH(ENTRIES), .AW(E_W)) u_bank (
      .clk(clk), .rst(rst), .we(we_s), .wa(w_entry), .wd(wd_s),
      .ra(rd_idx[E_W-1:0]), .rb(lk_idx[E_W-1:0]), .da(ha[s]), .db(lb[s]));
    assign lk_entry[32*s +: 32] =
      lk_in_q ? host_view(3'(s), lb[s], lb[5][2:0], pm_b) : 32'h0;
  end

  kt_pmbits #(.ENTRIES(ENTRIES), .E_W(E_W), .IDX_W(IDX_W)) u_pm (
    .clk(clk), .rst(rst), .set_en(pm_set_en), .set_idx(pm_idx), .set_val(pm_val),
    .ra(rd_idx[E_W-1:0]), .rb(lk_idx[E_W-1:0]), .qa(pm_a), .qb(pm_b));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_in_q   <= 1'b0;
      lk_in_q   <= 1'b0;
      rd_slot_q <= '0;
    end else begin
      rd_in_q   <= rd_in;
      lk_in_q   <= lk_in;
      rd_slot_q <= rd_addr[2:0];
    end
  end

  assign rd_data = rd_in_q ? host_view(rd_slot_q, ha[rd_slot_q], ha[5][2:0], pm_a) : 32'h0;

  assert_oor_read_R9: assert property (@(posedge clk) disable iff (rst)
    (32'(rd_addr[ADDR_W-1:3]) >= 32'(ENTRIES)) |=> (rd_data == 32'h0));

  assert_half_width_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_addr[2:0] == 3'd1 || rd_addr[2:0] == 3'd3 || rd_addr[2:0] == 3'd7)
    |=> (rd_data[31:16] == 16'h0));

  assert_lookup_oor_R11: assert property (@(posedge clk) disable iff (rst)
    (32'(lk_idx) >= 32'(ENTRIES)) |=> (lk_entry == 256'h0));
endmodule

// File: tb/keytab_pairfile_bench.sv
module keytab_pairfile_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N      = 128;
  localparam int GAP    = 64;
  localparam int IDX_W  = 8;
  localparam int ADDR_W = 11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [31:0]       rd_data;
  logic [IDX_W-1:0]  lk_idx = '0;
  logic [255:0]      lk_entry;
  logic              pm_set_en = 1'b0;
  logic [IDX_W-1:0]  pm_idx = '0;
  logic              pm_val = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_w [N][8];
  logic        m_pm [N];
  bit          s_v;
  int          s_idx, s_pair;
  logic [31:0] s_d;

  always #4 clk = ~clk;

  keytab_pairfile u_keytab_pairfile (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .lk_idx(lk_idx), .lk_entry(lk_entry),
    .pm_set_en(pm_set_en), .pm_idx(pm_idx), .pm_val(pm_val));

  function automatic logic [31:0] fix_odd(int slot, logic [31:0] d);
    if (slot == 1 || slot == 3 || slot == 7) return {16'h0, d[15:0]};
    if (slot == 5) return d & 32'h0000_01F7;
    return d;
  endfunction

  function automatic logic [31:0] exp_rd(int idx, int slot);
    logic [31:0] w;
    if (idx >= N) return 32'h0;
    w = m_w[idx][slot];
    if (slot == 4 && (m_w[idx][5][2:0] == 3'd1 || m_w[idx][5][2:0] == 3'd2))
      w = {24'h0, w[7:0]};
    if (slot == 5) w[3] = m_pm[idx];
    return w;
  endfunction

  function automatic logic [255:0] exp_lk(int idx);
    logic [255:0] r;
    for (int s = 0; s < 8; s++) r[32*s +: 32] = exp_rd(idx, s);
    return r;
  endfunction

  task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, int slot, logic [31:0] d);
    wr_en = 1'b1;
    wr_addr = ADDR_W'(idx * 8 + slot);
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < N) begin
      if (slot % 2 == 0) begin
        s_v = 1'b1; s_idx = idx; s_pair = slot / 2; s_d = d;
      end else begin
        if (!(slot == 5 && d[2:0] == 3'd4 && idx + GAP >= N)) begin
          if (s_v && s_idx == idx && s_pair == slot / 2) m_w[idx][slot-1] = s_d;
          m_w[idx][slot] = fix_odd(slot, d);
        end
        s_v = 1'b0;
      end
    end
  endtask

  task automatic rd(string tag, int idx, int slot);
    rd_addr = ADDR_W'(idx * 8 + slot);
    @(negedge clk);
    chk32(tag, rd_data, exp_rd(idx, slot));
  endtask

  task automatic lk(string tag, int idx);
    lk_idx = IDX_W'(idx);
    @(negedge clk);
    n_chk++;
    if (lk_entry !== exp_lk(idx)) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, lk_entry, exp_lk(idx));
    end
  endtask

  task automatic pm(int idx, logic v);
    pm_set_en = 1'b1; pm_idx = IDX_W'(idx); pm_val = v;
    @(negedge clk);
    pm_set_en = 1'b0;
    if (idx < N) m_pm[idx] = v;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int pool [8] = '{0, 1, 62, 63, 64, 65, 127, 200};
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < N; i++) begin
      m_pm[i] = 1'b0;
      for (int s = 0; s < 8; s++) m_w[i][s] = 32'h0;
    end
    s_v = 1'b0; s_idx = 0; s_pair = 0; s_d = 32'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10 reset contents
    rd("R10 reset key0", 0, 0);
    rd("R10 reset addr1", 127, 7);
    lk("R10 reset lookup", 5);

    // R2 even write alone is invisible, odd write commits pair
    wr(3, 0, 32'hA5A5_0001);
    rd("R2 staged not visible", 3, 0);
    wr(3, 1, 32'hDEAD_BEEF);
    rd("R2 pair committed lo", 3, 0);
    rd("R4 key1 upper zero", 3, 1);
    rd("R1 neighbour entry untouched", 2, 0);
    rd("R1 neighbour entry untouched", 4, 0);

    // R3 restaging and odd-only commit
    wr(3, 2, 32'h1111_1111);
    wr(3, 2, 32'h2222_2222);
    wr(3, 3, 32'h0000_3333);
    rd("R3 later even wins", 3, 2);
    wr(3, 3, 32'h0000_4444);
    rd("R3 odd-only keeps even", 3, 2);
    rd("R3 odd-only odd value", 3, 3);
    wr(9, 7, 32'hFFFF_8001);
    rd("R3 odd-only fresh even zero", 9, 6);
    rd("R4 addr1 upper zero", 9, 7);

    // R5/R6 type layout and key4 narrowing
    wr(3, 4, 32'h1234_5678);
    wr(3, 5, 32'hFFFF_FFFA);
    rd("R6 type masked", 3, 5);
    rd("R5 key4 narrowed for 104-bit", 3, 4);
    wr(3, 5, 32'h0000_0003);
    rd("R5 key4 full for 128-bit", 3, 4);

    // R7 MAC-owned flag
    pm(3, 1'b1);
    rd("R7 flag set by MAC", 3, 5);
    wr(3, 5, 32'h0000_0001);
    rd("R7 host write keeps flag", 3, 5);
    wr(4, 5, 32'h0000_0008);
    rd("R7 host bit3 ignored", 4, 5);

    // R8 companion range
    wr(64, 4, 32'hCAFE_0064);
    wr(64, 5, 32'h0000_0004);
    rd("R8 tkip rejected type", 64, 5);
    rd("R8 tkip rejected key4", 64, 4);
    wr(63, 4, 32'hCAFE_0063);
    wr(63, 5, 32'h0000_0004);
    rd("R8 tkip accepted type", 63, 5);
    rd("R8 tkip accepted key4", 63, 4);

    // R9 out-of-range indices, including one that aliases entry 72
    wr(200, 0, 32'h0BAD_0BAD);
    wr(200, 1, 32'h0000_0BAD);
    rd("R9 oor read zero", 200, 0);
    rd("R9 alias entry untouched", 72, 0);
    rd("R9 alias entry untouched", 72, 1);
    lk("R9 oor lookup zero", 200);

    // R11 whole-entry lookup
    lk("R11 lookup entry 3", 3);
    lk("R11 lookup entry 63", 63);

    // Random mix
    for (int it = 0; it < 4000; it++) begin
      int op, idx, slot;
      op   = $urandom % 10;
      idx  = pool[$urandom % 8];
      slot = $urandom % 8;
      if (op < 5) wr(idx, slot, $urandom);
      else if (op < 8) rd("R1 R5 R6 random read", idx, slot);
      else if (op < 9) lk("R11 random lookup", idx);
      else pm(idx, 1'($urandom % 2));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule